// File: doc/BRIEF.md
# Mailbox Command Requester Sequencer

This block runs one command transaction against a register mailbox on behalf of a host. A client gives it a command of four 64-bit words and two 4-bit masks. The request mask picks the command words to write and the response mask picks the response words to read. On a start pulse the block writes only the picked words over a single-cycle register-bus master port. It then rings the target's doorbell and polls the host-side doorbell until a response flag shows up or a poll limit runs out. It reads the picked response words, clears the response flag and ends with a one-cycle done pulse and three error flags.

All bus addresses are fixed offsets from a base-address parameter. The bus port is a plain register port. A transfer is one cycle long: `bus_req_o` is high with the address, direction and write data, and for a read `bus_rdata_i` is valid in that same cycle and is sampled at its closing clock edge. Command word n sits in `cmd_i[64n+63:64n]` and response word n sits in `rsp_o[64n+63:64n]`. In word 0, from the most significant bit down, the fields are: 16-bit primary status (response) or reserved (command), 16 bits of secondary status or flags, a 16-bit sequence ID at bits [31:16], an 8-bit class and an 8-bit command.

Top module: `mbx_cmd_sequencer`

## Requirements
- R1: For each set bit n of the request mask, in ascending n, exactly one bus write goes to BASE+0x50+n carrying command word n. Words whose bits are clear get no bus cycle.
- R2: Right after the last request write, or straight after start when the request mask is zero, one write goes to BASE+0x62 with data 0x8000_0000_0000_0000.
- R3: After the doorbell write the block reads BASE+0x63 on every cycle until a read returns bit 63 set.
- R4: After the flag is seen, for each set bit n of the response mask, in ascending n, one read of BASE+0x54+n is made and its data appears as word n of `rsp_o`.
- R5: After the response reads, one write goes to BASE+0x64 with data 0x7FFF_FFFF_FFFF_FFFF. In the next cycle `done_o` is high.
- R6: The poll limit is SHORT_CYCLES reads when `long_to_i` is low at start and LONG_CYCLES reads when it is high.
- R7: If the last allowed poll read still shows bit 63 clear, the block does no response read and no clear write. It raises `err_timeout_o` and holds `err_seq_o` and `err_fail_o` low.
- R8: At start every word of `rsp_o` is preset to all ones, so a word that is not read stays all ones.
- R9: On a completed transaction `err_seq_o` is high exactly when `rsp_o[31:16]` differs from `cmd_i[31:16]` as captured at start.
- R10: On a completed transaction `err_fail_o` is high exactly when `rsp_o[63:48]` is nonzero.
- R11: A start while `busy_o` is high is ignored. It changes neither the bus traffic nor the results of the running transaction.
- R12: `done_o` is high for exactly one cycle. With a request words, b response words and the flag seen on poll read p, it comes a+p+b+3 cycles after the start cycle.
- R13: After reset `busy_o`, `done_o`, `bus_req_o` and the error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| long_to_i | input | 1 | Selects the long poll limit |
| req_mask_i | input | 4 | Request words to write |
| rsp_mask_i | input | 4 | Response words to read |
| cmd_i | input | 256 | Four command words |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_timeout_o | output | 1 | Poll limit expired |
| err_seq_o | output | 1 | Returned sequence ID differs |
| err_fail_o | output | 1 | Nonzero primary status |
| rsp_o | output | 256 | Four captured response words |
| bus_req_o | output | 1 | Bus transfer this cycle |
| bus_we_o | output | 1 | Transfer is a write |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 64 | Bus write data |
| bus_rdata_i | input | 64 | Bus read data, same cycle |

## Verification
The start pulse is driven half a cycle before the edge that samples it. The bench then counts falling edges, so `done_o` must first be seen at count a+p+b+3 on a completed transaction and at a+L+2 on a timeout with limit L. One cycle later it must be low again. Every bus transfer is logged at the rising edge in which it happens, and the log is compared entry by entry with the expected order of writes, polls, reads and the clear. The log must have no extra entries. The results and flags are compared on the falling edge where `done_o` is high, and they are held until the next start.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;
  localparam int MBX_WORDS = 4;
  localparam int MBX_DW    = 64;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_RING, ST_POLL, ST_READ, ST_CLEAR, ST_DONE
  } seq_state_e;

  localparam logic [7:0] OFS_REQ  = 8'h50;
  localparam logic [7:0] OFS_RSP  = 8'h54;
  localparam logic [7:0] OFS_RING = 8'h62;
  localparam logic [7:0] OFS_POLL = 8'h63;
  localparam logic [7:0] OFS_CLR  = 8'h64;

  localparam logic [MBX_DW-1:0] RING_VALUE = 64'h8000_0000_0000_0000;
  localparam logic [MBX_DW-1:0] CLR_VALUE  = 64'h7FFF_FFFF_FFFF_FFFF;
endpackage

// File: rtl/mbx_word_pick.sv
module mbx_word_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx    = IW'(i);
        onehot = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit_m1,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == limit_m1);

  AST_POLL_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (cnt_q < limit_m1)); // R6
endmodule

// File: rtl/mbx_rsp_store.sv
module mbx_rsp_store #(
  parameter int N  = 4,
  parameter int DW = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preset,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [N*DW-1:0] words
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [DW-1:0] word_q;
    logic          word_en;

    assign word_en = preset | (we && (idx == IW'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '1;
      else if (word_en) word_q <= preset ? '1 : wdata;
    end

    assign words[g*DW +: DW] = word_q;
  end

  AST_PRESET_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (&words)); // R8
endmodule

// File: rtl/mbx_cmd_sequencer.sv
module mbx_cmd_sequencer
  import mbx_seq_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 32'h000D_0000,
  parameter logic [63:0]       SHORT_CYCLES = 64'd10_000_000,
  parameter logic [63:0]       LONG_CYCLES  = 64'd3_000_000_000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      long_to_i,
  input  logic [MBX_WORDS-1:0]      req_mask_i,
  input  logic [MBX_WORDS-1:0]      rsp_mask_i,
  input  logic [MBX_WORDS*MBX_DW-1:0] cmd_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_timeout_o,
  output logic                      err_seq_o,
  output logic                      err_fail_o,
  output logic [MBX_WORDS*MBX_DW-1:0] rsp_o,
  output logic                      bus_req_o,
  output logic                      bus_we_o,
  output logic [ADDR_W-1:0]         bus_addr_o,
  output logic [MBX_DW-1:0]         bus_wdata_o,
  input  logic [MBX_DW-1:0]         bus_rdata_i
);
  localparam int IW = $clog2(MBX_WORDS);
  localparam int CW = $clog2(LONG_CYCLES + 64'd1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_CYCLES - 64'd1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYCLES - 64'd1);

  // reset: asynchronous assertion, synchronous release
  logic rst_s1_q, rst_nq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_nq   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_nq   <= rst_s1_q;
    end
  end

  seq_state_e                   state_q, state_d;
  logic [MBX_WORDS-1:0]         pend_q, pend_d;
  logic [MBX_WORDS-1:0]         rspm_q;
  logic [MBX_WORDS*MBX_DW-1:0]  cmd_q;
  logic [CW-1:0]                lim_q;
  logic                         err_to_q, err_seq_q, err_fail_q;

  logic                         load, set_to, eval;
  logic                         tmr_clr, tmr_inc, tmr_expire;
  logic                         cap_we;
  logic [IW-1:0]                pick_idx;
  logic [MBX_WORDS-1:0]         pick_oh;
  logic                         flag_seen;

  mbx_word_pick #(.N(MBX_WORDS), .IW(IW)) u_pick (
    .mask   (pend_q),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  mbx_poll_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_nq),
    .clr      (tmr_clr),
    .inc      (tmr_inc),
    .limit_m1 (lim_q),
    .expire   (tmr_expire)
  );

  mbx_rsp_store #(.N(MBX_WORDS), .DW(MBX_DW), .IW(IW)) u_store (
    .clk    (clk),
    .rst_n  (rst_nq),
    .preset (load),
    .we     (cap_we),
    .idx    (pick_idx),
    .wdata  (bus_rdata_i),
    .words  (rsp_o)
  );

  assign flag_seen = bus_rdata_i[MBX_DW-1];

  // next state and bus drive
  always_comb begin
    state_d     = state_q;
    pend_d      = pend_q;
    load        = 1'b0;
    set_to      = 1'b0;
    eval        = 1'b0;
    tmr_clr     = 1'b0;
    tmr_inc     = 1'b0;
    cap_we      = 1'b0;
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = BASE_ADDR;
    bus_wdata_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          pend_d  = req_mask_i;
          state_d = (|req_mask_i) ? ST_WRITE : ST_RING;
        end
      end
      ST_WRITE: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = BASE_ADDR + ADDR_W'(OFS_REQ) + ADDR_W'(pick_idx);
        bus_wdata_o = cmd_q[pick_idx*MBX_DW +: MBX_DW];
        pend_d      = pend_q & ~pick_oh;
        if (!(|pend_d)) state_d = ST_RING;
      end
      ST_RING: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = BASE_ADDR + ADDR_W'(OFS_RING);
        bus_wdata_o = RING_VALUE;
        tmr_clr     = 1'b1;
        state_d     = ST_POLL;
      end
      ST_POLL: begin
        bus_req_o  = 1'b1;
        bus_addr_o = BASE_ADDR + ADDR_W'(OFS_POLL);
        if (flag_seen) begin
          pend_d  = rspm_q;
          state_d = (|rspm_q) ? ST_READ : ST_CLEAR;
        end else if (tmr_expire) begin
          set_to  = 1'b1;
          state_d = ST_DONE;
        end else begin
          tmr_inc = 1'b1;
        end
      end
      ST_READ: begin
        bus_req_o  = 1'b1;
        bus_addr_o = BASE_ADDR + ADDR_W'(OFS_RSP) + ADDR_W'(pick_idx);
        cap_we     = 1'b1;
        pend_d     = pend_q & ~pick_oh;
        if (!(|pend_d)) state_d = ST_CLEAR;
      end
      ST_CLEAR: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = BASE_ADDR + ADDR_W'(OFS_CLR);
        bus_wdata_o = CLR_VALUE;
        eval        = 1'b1;
        state_d     = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      cmd_q  <= '0;
      rspm_q <= '0;
      lim_q  <= '0;
    end else if (load) begin
      cmd_q  <= cmd_i;
      rspm_q <= rsp_mask_i;
      lim_q  <= long_to_i ? LONG_M1 : SHORT_M1;
    end
  end

  always_ff @(posedge clk or negedge rst_nq) begin
    if (!rst_nq) begin
      err_to_q   <= 1'b0;
      err_seq_q  <= 1'b0;
      err_fail_q <= 1'b0;
    end else if (load) begin
      err_to_q   <= 1'b0;
      err_seq_q  <= 1'b0;
      err_fail_q <= 1'b0;
    end else if (set_to) begin
      err_to_q   <= 1'b1;
    end else if (eval) begin
      err_seq_q  <= (rsp_o[31:16] != cmd_q[31:16]);
      err_fail_q <= (rsp_o[63:48] != 16'h0000);
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign err_timeout_o = err_to_q;
  assign err_seq_o     = err_seq_q;
  assign err_fail_o    = err_fail_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_nq)
    done_o |=> !done_o); // R12
  AST_BUSY_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_nq)
    busy_o |=> $stable(cmd_q)); // R11
  AST_NO_READ_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_nq)
    (state_q == ST_READ || state_q == ST_CLEAR) |-> !err_to_q); // R7
  AST_WRITE_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_nq)
    (state_q == ST_WRITE) |-> (|pend_q)); // R1
  AST_READ_HAS_WORD: assert property (@(posedge clk) disable iff (!rst_nq)
    (state_q == ST_READ) |-> (|pend_q)); // R4
endmodule

// File: tb/mbx_cmd_sequencer_bench.sv
module mbx_cmd_sequencer_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE  = 32'h000D_0000;
  localparam int          SHORT = 8;
  localparam int          LONG  = 40;

  logic         clk, rst_n;
  logic         start_i, long_to_i;
  logic [3:0]   req_mask_i, rsp_mask_i;
  logic [255:0] cmd_i;
  logic         busy_o, done_o, err_timeout_o, err_seq_o, err_fail_o;
  logic [255:0] rsp_o;
  logic         bus_req_o, bus_we_o;
  logic [31:0]  bus_addr_o;
  logic [63:0]  bus_wdata_o, bus_rdata_i;

  mbx_cmd_sequencer #(
    .ADDR_W(32), .BASE_ADDR(BASE),
    .SHORT_CYCLES(64'(SHORT)), .LONG_CYCLES(64'(LONG))
  ) u_mbx_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .long_to_i(long_to_i),
    .req_mask_i(req_mask_i), .rsp_mask_i(rsp_mask_i), .cmd_i(cmd_i),
    .busy_o(busy_o), .done_o(done_o), .err_timeout_o(err_timeout_o),
    .err_seq_o(err_seq_o), .err_fail_o(err_fail_o), .rsp_o(rsp_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // mailbox target model
  logic [63:0] resp_mem [4];
  int          ready_after = 0;
  int          poll_base = 0;
  int          poll_seen = 0;
  logic        log_we   [512];
  logic [31:0] log_addr [512];
  logic [63:0] log_data [512];
  int          log_n = 0;

  always_comb begin
    bus_rdata_i = '0;
    if (bus_addr_o == BASE + 32'h63)
      bus_rdata_i[63] = (ready_after != 0) && ((poll_seen - poll_base + 1) >= ready_after);
    else if (bus_addr_o[31:2] == ((BASE + 32'h54) >> 2))
      bus_rdata_i = resp_mem[bus_addr_o[1:0]];
  end

  always @(posedge clk) begin
    if (bus_req_o) begin
      if (log_n < 512) begin
        log_we[log_n]   <= bus_we_o;
        log_addr[log_n] <= bus_addr_o;
        log_data[log_n] <= bus_we_o ? bus_wdata_o : 64'h0;
      end
      log_n <= log_n + 1;
      if (!bus_we_o && bus_addr_o == BASE + 32'h63) poll_seen <= poll_seen + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // walks the log from index k and compares with the expected transaction
  task automatic chk_log(input string req, input int k0, input logic [255:0] cmd,
                         input logic [3:0] reqm, input logic [3:0] rspm,
                         input int polls, input bit timed_out);
    int k = k0;
    for (int n = 0; n < 4; n++) if (reqm[n]) begin
      chk("R1", "req write dir", 64'(log_we[k]), 64'd1);
      chk("R1", "req write addr", 64'(log_addr[k]), 64'(BASE + 32'h50 + 32'(n)));
      chk("R1", "req write data", log_data[k], cmd[n*64 +: 64]);
      k++;
    end
    chk("R2", "ring addr", 64'(log_addr[k]), 64'(BASE + 32'h62));
    chk("R2", "ring data", log_data[k], 64'h8000_0000_0000_0000);
    k++;
    for (int p = 0; p < polls; p++) begin
      chk("R3", "poll addr", 64'(log_addr[k]), 64'(BASE + 32'h63));
      chk("R3", "poll dir", 64'(log_we[k]), 64'd0);
      k++;
    end
    if (!timed_out) begin
      for (int n = 0; n < 4; n++) if (rspm[n]) begin
        chk("R4", "rsp read addr", 64'(log_addr[k]), 64'(BASE + 32'h54 + 32'(n)));
        chk("R4", "rsp read dir", 64'(log_we[k]), 64'd0);
        k++;
      end
      chk("R5", "clear addr", 64'(log_addr[k]), 64'(BASE + 32'h64));
      chk("R5", "clear data", log_data[k], 64'h7FFF_FFFF_FFFF_FFFF);
      k++;
    end
    chk(req, "transfer count", 64'(log_n - k0), 64'(k - k0));
  endtask

  // runs one transaction; returns the falling-edge count at which done was seen
  task automatic run_txn(input logic [255:0] cmd, input logic [3:0] reqm, input logic [3:0] rspm,
                         input bit lng, input int ready, input bit poke, output int cyc);
    @(negedge clk);
    ready_after = ready;
    poll_base   = poll_seen;
    cmd_i = cmd; req_mask_i = reqm; rsp_mask_i = rspm; long_to_i = lng;
    start_i = 1'b1;
    @(negedge clk);
    cyc = 1;
    start_i = 1'b0;
    while (!done_o && cyc < 2000) begin
      if (poke && cyc == 2) begin
        cmd_i = ~cmd; req_mask_i = 4'hF; rsp_mask_i = 4'hF; long_to_i = ~lng;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    if (!done_o) chk("R12", "done never seen", 64'd0, 64'd1);
  endtask

  task automatic after_done(input string req);
    @(negedge clk);
    chk(req, "done low after pulse", 64'(done_o), 64'd0);
  endtask

  function automatic logic [255:0] expect_rsp(input logic [3:0] rspm);
    logic [255:0] r = '1;
    for (int n = 0; n < 4; n++) if (rspm[n]) r[n*64 +: 64] = resp_mem[n];
    return r;
  endfunction

  task automatic t_reset();
    chk("R13", "busy", 64'(busy_o), 64'd0);
    chk("R13", "done", 64'(done_o), 64'd0);
    chk("R13", "bus_req", 64'(bus_req_o), 64'd0);
    chk("R13", "errors", 64'({err_timeout_o, err_seq_o, err_fail_o}), 64'd0);
  endtask

  task automatic t_full();
    logic [255:0] c = {64'h3333_0000_0000_0003, 64'h2222_0000_0000_0002,
                       64'h1111_0000_0000_0001, 64'h0000_0100_1234_D101};
    int cyc, k0;
    resp_mem[0] = 64'h0000_0000_1234_D101; resp_mem[1] = 64'hA1;
    resp_mem[2] = 64'hA2; resp_mem[3] = 64'hA3;
    k0 = log_n;
    run_txn(c, 4'hF, 4'hF, 1'b0, 3, 1'b0, cyc);
    chk("R12", "latency full", 64'(cyc), 64'(4 + 3 + 4 + 3));
    chk("R4", "rsp words", rsp_o[255:192], expect_rsp(4'hF)[255:192]);
    chk("R4", "rsp word0", rsp_o[63:0], resp_mem[0]);
    chk("R9", "seq match", 64'(err_seq_o), 64'd0);
    chk("R10", "status ok", 64'(err_fail_o), 64'd0);
    chk("R7", "no timeout", 64'(err_timeout_o), 64'd0);
    chk_log("R5", k0, c, 4'hF, 4'hF, 3, 1'b0);
    after_done("R12");
  endtask

  task automatic t_sparse();
    logic [255:0] c = {64'hDEAD, 64'hBEEF, 64'h55, 64'h0000_0201_0042_D101};
    int cyc, k0;
    resp_mem[0] = 64'h0002_0008_0043_D101;
    k0 = log_n;
    run_txn(c, 4'h3, 4'h1, 1'b0, 1, 1'b0, cyc);
    chk("R12", "latency sparse", 64'(cyc), 64'(2 + 1 + 1 + 3));
    chk("R8", "unread words ones", rsp_o[255:64], {192{1'b1}});
    chk("R4", "word0", rsp_o[63:0], resp_mem[0]);
    chk("R9", "seq mismatch", 64'(err_seq_o), 64'd1);
    chk("R10", "status fail", 64'(err_fail_o), 64'd1);
    chk_log("R1", k0, c, 4'h3, 4'h1, 1, 1'b0);
    after_done("R12");
  endtask

  task automatic t_nomask();
    logic [255:0] c = {192'h0, 64'h0000_0000_1234_D101};
    int cyc, k0;
    k0 = log_n;
    run_txn(c, 4'h0, 4'h0, 1'b0, 2, 1'b0, cyc);
    chk("R12", "latency no masks", 64'(cyc), 64'(0 + 2 + 0 + 3));
    chk("R8", "all words ones", rsp_o[127:0], {128{1'b1}});
    chk("R9", "preset seq differs", 64'(err_seq_o), 64'd1);
    chk("R10", "preset status fails", 64'(err_fail_o), 64'd1);
    chk_log("R2", k0, c, 4'h0, 4'h0, 2, 1'b0);
  endtask

  task automatic t_timeout_short();
    logic [255:0] c = {192'h0, 64'h0000_0000_0077_D101};
    int cyc, k0;
    k0 = log_n;
    run_txn(c, 4'h1, 4'hF, 1'b0, 0, 1'b0, cyc);
    chk("R6", "short limit latency", 64'(cyc), 64'(1 + SHORT + 2));
    chk("R7", "timeout flag", 64'(err_timeout_o), 64'd1);
    chk("R7", "seq/fail low", 64'({err_seq_o, err_fail_o}), 64'd0);
    chk("R8", "words stay ones", rsp_o[255:128], {128{1'b1}});
    chk_log("R7", k0, c, 4'h1, 4'hF, SHORT, 1'b1);
  endtask

  task automatic t_long_ok();
    logic [255:0] c = {192'h0, 64'h0000_0000_0099_D101};
    int cyc, k0;
    resp_mem[0] = 64'h0000_0000_0099_D101;
    k0 = log_n;
    run_txn(c, 4'h1, 4'h1, 1'b1, 20, 1'b0, cyc);
    chk("R6", "long limit allows late flag", 64'(err_timeout_o), 64'd0);
    chk("R12", "latency long", 64'(cyc), 64'(1 + 20 + 1 + 3));
    chk("R9", "seq match", 64'(err_seq_o), 64'd0);
    chk_log("R6", k0, c, 4'h1, 4'h1, 20, 1'b0);
  endtask

  task automatic t_timeout_long();
    logic [255:0] c = '0;
    int cyc, k0;
    k0 = log_n;
    run_txn(c, 4'h0, 4'h1, 1'b1, 0, 1'b0, cyc);
    chk("R6", "long limit latency", 64'(cyc), 64'(0 + LONG + 2));
    chk("R7", "timeout flag long", 64'(err_timeout_o), 64'd1);
    chk_log("R6", k0, c, 4'h0, 4'h1, LONG, 1'b1);
  endtask

  task automatic t_busy_start();
    logic [255:0] c = {128'h0, 64'h77, 64'h0000_0000_0abc_D101};
    int cyc, k0;
    resp_mem[0] = 64'h0000_0000_0abc_D101;
    k0 = log_n;
    run_txn(c, 4'h2, 4'h1, 1'b0, 2, 1'b1, cyc);
    chk("R11", "latency unchanged", 64'(cyc), 64'(1 + 2 + 1 + 3));
    chk("R11", "result of first command", 64'({err_timeout_o, err_seq_o, err_fail_o}), 64'd0);
    chk_log("R11", k0, c, 4'h2, 4'h1, 2, 1'b0);
    after_done("R11");
    chk("R11", "idle after", 64'(busy_o), 64'd0);
    chk("R11", "no second transaction", 64'(bus_req_o), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; long_to_i = 1'b0;
    req_mask_i = '0; rsp_mask_i = '0; cmd_i = '0;
    for (int i = 0; i < 4; i++) resp_mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full();
    t_sparse();
    t_nomask();
    t_timeout_short();
    t_long_ok();
    t_timeout_long();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule